// File: doc/BRIEF.md
# SD/MMC Command Line Engine

This block is the host side of the command line of an SD/MMC card bus. Software first loads a 32-bit argument. It then writes a command word that holds a 6-bit command index, a response kind, a driver mode flag and a latency flag. Writing the command word launches a 48-bit command frame at once. The frame leaves MSB first: a start bit of 0, a direction bit of 1, the index, the argument, a CRC7 over those 40 bits, and a stop bit of 1.

When the command expects a response, the engine watches the line for a start bit inside a bounded window. It then shifts in a 48-bit or 136-bit response, checks the CRC and the stop bit, and keeps the payload for word-wise reads. A four-bit status vector reports a ready flag, a timeout flag, a CRC error flag and a stop-bit error flag. Every step of the engine is paced by a card-clock enable, so the block runs on the system clock and advances only on card-clock ticks.

Top module: `sdc_cmd_engine`

## Requirements
- R1: The frame is sent MSB first as {0, 1, index[5:0], argument[31:0], crc7, 1}. The CRC7 uses the polynomial x^7+x^3+1 with a zero seed, over the first 40 bits. For index 0 with argument 0 the frame is 48'h40_0000_0000_95. When idle, cmd_oe_o is 0 and cmd_o is 1.
- R2: Writing cmd_i in idle shows the first frame bit on the next cycle. Each later card tick advances one bit. A cmd_we_i pulse while a command is in progress is ignored.
- R3: status_o[0] is the ready flag. It is 1 after reset and 0 from the cycle after a launch. It returns to 1 in the cycle after the last frame bit's tick when no response is expected. Otherwise it returns to 1 in the cycle after the tick that samples the last response bit, or after a timeout.
- R4: cmd_i[7:6] selects the response kind: 0 none, 1 48-bit, 2 136-bit, 3 48-bit with no CRC check.
- R5: cmd_i[9] selects the start-bit window, counted in card ticks after the last frame bit. A value of 0 gives 5 ticks and a value of 1 gives 64 ticks. If no 0 is sampled inside the window, status_o[1] and ready are set in the cycle after the final window tick.
- R6: When cmd_i[8]=1, the line is open drain: cmd_oe_o is high only for 0 bits and cmd_o is 0. When cmd_i[8]=0, the line is push-pull: cmd_oe_o is high for all 48 bits and cmd_o carries the bit.
- R7: The CRC7 is computed over response bits 47:8 for a 48-bit response, or bits 127:8 for a 136-bit response, and compared with bits 7:1. A mismatch sets status_o[2]. Kinds 0 and 3 never set it.
- R8: A response whose final bit is 0 sets status_o[3].
- R9: rsp_word_o shows the current response word, most significant first. Each rsp_rd_i pulse advances to the next word and wraps after four. A 136-bit response yields bits 127:0. A 48-bit response yields bits 39:8 followed by three zero words. The pointer returns to the first word when a response is captured.
- R10: While card_ce_i is low, the engine holds its line outputs, counters and flags.
- R11: A launch clears status_o[3:1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| card_ce_i | input | 1 | Card-clock tick enable |
| arg_i | input | 32 | Argument write data |
| arg_we_i | input | 1 | Argument write strobe |
| cmd_i | input | 10 | Command word: [5:0] index, [7:6] response kind, [8] open drain, [9] long window |
| cmd_we_i | input | 1 | Command write strobe, launches in idle |
| cmd_line_i | input | 1 | Sampled CMD line from the card |
| cmd_o | output | 1 | CMD line output value |
| cmd_oe_o | output | 1 | CMD line output enable |
| rsp_rd_i | input | 1 | Response word read strobe |
| rsp_word_o | output | 32 | Current response word |
| status_o | output | 4 | {stop error, CRC error, timeout, ready} |

## Verification
The bench sweeps all 64 command indices against frames built arithmetically. It also pins the known frame for index 0, so an off-by-one shift or a reflected CRC shows up as a wrong frame. The window edges are hit exactly: a start bit on the last allowed tick must be accepted, and silence must raise timeout on precisely the following cycle, for both latency settings. A counter off by one would time out early or late. Corrupted CRC and stop bits are injected for each response kind, so a CRC range that wrongly includes the 136-bit header, or a check that still runs for kind 3, flags the wrong case. A command written while busy must leave the outgoing frame unchanged. Holding the tick enable low must freeze the line.

// File: rtl/sdc_cmd_pkg.sv
package sdc_cmd_pkg;
  localparam int unsigned IDX_W     = 6;
  localparam int unsigned ARG_W     = 32;
  localparam int unsigned CRC_W     = 7;
  localparam int unsigned HEAD_W    = 2 + IDX_W + ARG_W;
  localparam int unsigned FRAME_LEN = HEAD_W + CRC_W + 1;
  localparam int unsigned CMD_W     = IDX_W + 4;
  localparam int unsigned SHORT_LEN = 48;
  localparam int unsigned LONG_LEN  = 136;
  localparam int unsigned CRC_LO    = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_SHORT = 2'd1,
    RSP_LONG  = 2'd2,
    RSP_RAW   = 2'd3
  } rsp_kind_e;

  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_WAIT, ST_RX} state_e;

  function automatic logic [CRC_W-1:0] crc7_step(logic [CRC_W-1:0] crc, logic b);
    logic fb;
    fb = b ^ crc[CRC_W-1];
    return {crc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  function automatic logic [CRC_W-1:0] crc7_head(logic [HEAD_W-1:0] head);
    logic [CRC_W-1:0] c;
    c = '0;
    for (int i = HEAD_W - 1; i >= 0; i--) c = crc7_step(c, head[i]);
    return c;
  endfunction
endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7
  import sdc_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= crc7_step(crc_q, bit_i);
  end

  assign crc_o = crc_q;

  AST_CRC_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (crc_o == '0)); // R7
endmodule

// File: rtl/sdc_rsp_buf.sv
module sdc_rsp_buf #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WORDS  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [WORD_W*WORDS-1:0] data_i,
  input  logic                    rd_i,
  output logic [WORD_W-1:0]       word_o
);
  localparam int unsigned BUF_W = WORD_W * WORDS;
  localparam int unsigned PTR_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(WORDS - 1);

  logic [BUF_W-1:0]  buf_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [WORD_W-1:0] words [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      ptr_q <= '0;
    end else if (load_i) begin
      buf_q <= data_i;
      ptr_q <= '0;
    end else if (rd_i) begin
      ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  // word 0 is the most significant slice
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign words[g] = buf_q[(WORDS-1-g)*WORD_W +: WORD_W];
  end

  assign word_o = words[ptr_q];

  AST_LOAD_TOP_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (word_o == $past(data_i[BUF_W-1 -: WORD_W]))); // R9
endmodule

// File: rtl/sdc_cmd_engine.sv
module sdc_cmd_engine
  import sdc_cmd_pkg::*;
#(
  parameter int unsigned WAIT_SHORT = 5,
  parameter int unsigned WAIT_LONG  = 64,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned RSP_WORDS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              card_ce_i,
  input  logic [ARG_W-1:0]  arg_i,
  input  logic              arg_we_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              cmd_we_i,
  input  logic              cmd_line_i,
  output logic              cmd_o,
  output logic              cmd_oe_o,
  input  logic              rsp_rd_i,
  output logic [WORD_W-1:0] rsp_word_o,
  output logic [3:0]        status_o
);
  localparam int unsigned BUF_W   = WORD_W * RSP_WORDS;
  localparam int unsigned CNT_MAX = (LONG_LEN > WAIT_LONG) ? LONG_LEN : WAIT_LONG;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_LEN - 1);

  state_e           state_q;
  rsp_kind_e        kind_q;
  logic [FRAME_LEN-1:0] tx_sreg_q;
  logic [BUF_W-2:0] rx_sreg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ARG_W-1:0] arg_q;
  logic             od_q, lat_q;
  logic             ready_q, tmo_q, crc_err_q, end_err_q;

  logic [IDX_W-1:0]  cmd_idx;
  logic [HEAD_W-1:0] head;
  logic              launch, start_seen, in_rng, crc_en, has_crc, rx_done;
  logic [CNT_W-1:0]  wait_lim, rsp_len, rx_idx, pos, crc_hi;
  logic [BUF_W-1:0]  rx_new, buf_data;
  logic [CRC_W-1:0]  rx_crc;

  assign cmd_idx = cmd_i[IDX_W-1:0];
  assign head    = {2'b01, cmd_idx, arg_q};
  assign launch  = cmd_we_i && (state_q == ST_IDLE);

  assign wait_lim = lat_q ? CNT_W'(WAIT_LONG) : CNT_W'(WAIT_SHORT);
  assign rsp_len  = (kind_q == RSP_LONG) ? CNT_W'(LONG_LEN) : CNT_W'(SHORT_LEN);
  assign crc_hi   = (kind_q == RSP_LONG) ? CNT_W'(BUF_W - 1) : CNT_W'(SHORT_LEN - 1);
  assign has_crc  = (kind_q == RSP_SHORT) || (kind_q == RSP_LONG);

  // bit position of the response bit sampled on this tick
  assign rx_idx     = (state_q == ST_RX) ? cnt_q : '0;
  assign pos        = rsp_len - CNT_W'(1) - rx_idx;
  assign in_rng     = (pos >= CNT_W'(CRC_LO)) && (pos <= crc_hi);
  assign start_seen = ((state_q == ST_WAIT) && !cmd_line_i) || (state_q == ST_RX);
  assign crc_en     = card_ce_i && start_seen && in_rng;
  assign rx_new     = {rx_sreg_q, cmd_line_i};
  assign rx_done    = card_ce_i && (state_q == ST_RX) && (cnt_q == rsp_len - CNT_W'(1));

  assign buf_data = (kind_q == RSP_LONG) ? rx_new
                  : {rx_new[SHORT_LEN-CRC_LO-1:CRC_LO], {(BUF_W-WORD_W){1'b0}}};

  sdc_crc7 u_rx_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (launch),
    .en_i   (crc_en),
    .bit_i  (cmd_line_i),
    .crc_o  (rx_crc)
  );

  sdc_rsp_buf #(.WORD_W(WORD_W), .WORDS(RSP_WORDS)) u_rsp_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (rx_done),
    .data_i (buf_data),
    .rd_i   (rsp_rd_i),
    .word_o (rsp_word_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      kind_q    <= RSP_NONE;
      tx_sreg_q <= '0;
      rx_sreg_q <= '0;
      cnt_q     <= '0;
      arg_q     <= '0;
      od_q      <= 1'b0;
      lat_q     <= 1'b0;
      ready_q   <= 1'b1;
      tmo_q     <= 1'b0;
      crc_err_q <= 1'b0;
      end_err_q <= 1'b0;
    end else begin
      if (arg_we_i) arg_q <= arg_i;
      unique case (state_q)
        ST_IDLE: if (cmd_we_i) begin
          state_q   <= ST_TX;
          tx_sreg_q <= {head, crc7_head(head), 1'b1};
          kind_q    <= rsp_kind_e'(cmd_i[IDX_W+1:IDX_W]);
          od_q      <= cmd_i[IDX_W+2];
          lat_q     <= cmd_i[IDX_W+3];
          cnt_q     <= '0;
          ready_q   <= 1'b0;
          tmo_q     <= 1'b0;
          crc_err_q <= 1'b0;
          end_err_q <= 1'b0;
        end
        ST_TX: if (card_ce_i) begin
          tx_sreg_q <= {tx_sreg_q[FRAME_LEN-2:0], 1'b1};
          if (cnt_q == FRAME_LAST) begin
            cnt_q <= '0;
            if (kind_q == RSP_NONE) begin
              state_q <= ST_IDLE;
              ready_q <= 1'b1;
            end else begin
              state_q <= ST_WAIT;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT: if (card_ce_i) begin
          if (!cmd_line_i) begin
            state_q   <= ST_RX;
            rx_sreg_q <= rx_new[BUF_W-2:0];
            cnt_q     <= CNT_W'(1);
          end else if (cnt_q == wait_lim - CNT_W'(1)) begin
            state_q <= ST_IDLE;
            tmo_q   <= 1'b1;
            ready_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RX: if (card_ce_i) begin
          rx_sreg_q <= rx_new[BUF_W-2:0];
          if (rx_done) begin
            state_q   <= ST_IDLE;
            ready_q   <= 1'b1;
            crc_err_q <= has_crc && (rx_crc != rx_new[CRC_W:1]);
            end_err_q <= !rx_new[0];
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // open drain: only pull low, never drive high
  assign cmd_oe_o = (state_q == ST_TX) && (od_q ? !tx_sreg_q[FRAME_LEN-1] : 1'b1);
  assign cmd_o    = (state_q == ST_TX) ? (!od_q && tx_sreg_q[FRAME_LEN-1]) : 1'b1;
  assign status_o = {end_err_q, crc_err_q, tmo_q, ready_q};

  AST_READY_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> !status_o[0]); // R3
  AST_FLAGS_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> (status_o[3:1] == 3'b000)); // R11
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_TX) && !card_ce_i) |=> ($stable(cmd_o) && $stable(cmd_oe_o))); // R10
  AST_OD_NO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_TX) && od_q) |-> !(cmd_oe_o && cmd_o)); // R6
  AST_WAIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> (cnt_q < wait_lim)); // R5
  AST_TIMEOUT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[1]) |-> status_o[0]); // R5
endmodule

// File: tb/sdc_cmd_engine_tb.sv
module sdc_cmd_engine_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ce = 1'b1;
  logic [31:0]  arg = '0;
  logic         arg_we = 1'b0;
  logic [9:0]   cmd = '0;
  logic         cmd_we = 1'b0;
  logic         card_line = 1'b1;
  logic         cmd_o, cmd_oe;
  logic         rsp_rd = 1'b0;
  logic [31:0]  rsp_word;
  logic [3:0]   status;

  int nchk = 0;
  int nerr = 0;
  logic cur_od = 1'b0;

  always #5 clk = ~clk;

  sdc_cmd_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .card_ce_i(ce),
    .arg_i(arg), .arg_we_i(arg_we), .cmd_i(cmd), .cmd_we_i(cmd_we),
    .cmd_line_i(card_line), .cmd_o(cmd_o), .cmd_oe_o(cmd_oe),
    .rsp_rd_i(rsp_rd), .rsp_word_o(rsp_word), .status_o(status)
  );

  task automatic chk(input bit ok, input string req, input logic [135:0] act, input logic [135:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] bcrc(input logic [127:0] v, input int n);
    logic [6:0] c = '0;
    logic fb;
    for (int i = n - 1; i >= 0; i--) begin
      fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'b0001001;
    end
    return c;
  endfunction

  function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] a);
    logic [39:0] h = {2'b01, idx, a};
    return {h, bcrc({88'd0, h}, 40), 1'b1};
  endfunction

  task automatic launch(input logic [5:0] idx, input logic [31:0] a, input logic [1:0] kind,
                        input logic od, input logic lat);
    @(negedge clk);
    arg = a; arg_we = 1'b1;
    @(negedge clk);
    arg_we = 1'b0;
    cmd = {lat, od, kind, idx}; cmd_we = 1'b1;
    cur_od = od;
    @(negedge clk);
    cmd_we = 1'b0;
    chk(status == 4'b0000, "R3/R11 status after launch", status, 0);
  endtask

  // samples 48 bits starting at the current negedge; optional busy write
  task automatic capture(output logic [47:0] fr, input int busy_at);
    int bad = 0;
    logic b;
    fr = '0;
    for (int i = 0; i < 48; i++) begin
      if (i > 0) @(negedge clk);
      cmd_we = 1'b0;
      if (i == busy_at) begin
        cmd = 10'b00_0_0_000101; cmd_we = 1'b1;
      end
      b = cmd_oe ? cmd_o : 1'b1;
      fr = {fr[46:0], b};
      if (cur_od) begin
        if (cmd_oe && cmd_o) bad++;
      end else if (!cmd_oe) bad++;
    end
    chk(bad == 0, "R6 driver mode", bad, 0);
  endtask

  task automatic card_send(input int delay, input logic [135:0] bits, input int len);
    repeat (delay) begin @(negedge clk); card_line = 1'b1; end
    for (int i = len - 1; i >= 0; i--) begin
      @(negedge clk); card_line = bits[i];
    end
    @(negedge clk); card_line = 1'b1;
  endtask

  task automatic read_words(input logic [127:0] exp, input string req);
    for (int w = 0; w < 4; w++) begin
      chk(rsp_word == exp[127-32*w -: 32], req, rsp_word, exp[127-32*w -: 32]);
      rsp_rd = 1'b1;
      @(negedge clk);
      rsp_rd = 1'b0;
    end
    chk(rsp_word == exp[127:96], {req, " wrap"}, rsp_word, exp[127:96]);
  endtask

  function automatic logic [47:0] mk_short(input logic [5:0] idx, input logic [31:0] p,
                                           input logic crc_bad, input logic end_bit);
    logic [39:0] h = {2'b00, idx, p};
    return {h, bcrc({88'd0, h}, 40) ^ {6'd0, crc_bad}, end_bit};
  endfunction

  function automatic logic [135:0] mk_long(input logic [119:0] body, input logic crc_bad);
    return {8'h3F, body, bcrc({8'd0, body}, 120) ^ {6'd0, crc_bad}, 1'b1};
  endfunction

  initial begin : main
    logic [47:0]  fr;
    logic [47:0]  sr;
    logic [135:0] lr;
    int held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 4'b0001 && !cmd_oe && cmd_o, "R3/R1 reset state", {status, cmd_oe, cmd_o}, 6'b000101);

    // R1 known frame
    launch(6'd0, 32'd0, 2'd0, 1'b0, 1'b0);
    capture(fr, -1);
    chk(fr == 48'h40_0000_0000_95, "R1 index0 frame", fr, 48'h40_0000_0000_95);
    @(negedge clk);
    chk(status[0] == 1'b1, "R3 ready after frame", status, 1);

    // R1/R2 sweep every index, alternating driver mode
    for (int idx = 0; idx < 64; idx++) begin
      logic [31:0] a = (32'h01010101 * idx) ^ 32'hA55A_3CC3;
      launch(6'(idx), a, 2'd0, idx[0], 1'b0);
      capture(fr, -1);
      chk(fr == exp_frame(6'(idx), a), "R1 frame sweep", fr, exp_frame(6'(idx), a));
      @(negedge clk);
      chk(status == 4'b0001 && !cmd_oe, "R3 ready no response", status, 1);
    end

    // R2 write while busy ignored
    launch(6'd17, 32'h1234_5678, 2'd0, 1'b0, 1'b0);
    capture(fr, 10);
    chk(fr == exp_frame(6'd17, 32'h1234_5678), "R2 busy write ignored", fr, exp_frame(6'd17, 32'h1234_5678));
    @(negedge clk);
    cmd_we = 1'b0;
    repeat (3) @(negedge clk);
    chk(status == 4'b0001 && !cmd_oe, "R2 no second launch", {status, cmd_oe}, 5'b00010);

    // R10 hold with tick enable low
    launch(6'd9, 32'hCAFE_0001, 2'd0, 1'b0, 1'b0);
    ce = 1'b0;
    held = 0;
    repeat (20) begin
      @(negedge clk);
      if (!(cmd_oe && !cmd_o && status[0] == 1'b0)) held++;
    end
    chk(held == 0, "R10 frozen without tick", held, 0);
    ce = 1'b1;
    capture(fr, -1);
    chk(fr == exp_frame(6'd9, 32'hCAFE_0001), "R10 frame after hold", fr, exp_frame(6'd9, 32'hCAFE_0001));
    @(negedge clk);

    // R4/R5/R7/R9 short response on last allowed tick
    sr = mk_short(6'd17, 32'h0000_0900, 1'b0, 1'b1);
    launch(6'd17, 32'h0, 2'd1, 1'b0, 1'b0);
    capture(fr, -1);
    card_send(4, {88'd0, sr}, 48);
    chk(status == 4'b0001, "R5/R7 short ok at tick 4", status, 1);
    read_words({sr[39:8], 96'd0}, "R9 short words");

    // R5 timeout, short window
    launch(6'd13, 32'h0, 2'd1, 1'b0, 1'b0);
    capture(fr, -1);
    repeat (5) @(negedge clk);
    chk(status == 4'b0000, "R5 no timeout yet", status, 0);
    @(negedge clk);
    chk(status == 4'b0011, "R5 timeout short window", status, 3);

    // R5 long window: accepted at tick 63, timeout after 64
    launch(6'd13, 32'h0, 2'd1, 1'b0, 1'b1);
    capture(fr, -1);
    card_send(63, {88'd0, sr}, 48);
    chk(status == 4'b0001, "R5 long window accepts tick 63", status, 1);
    launch(6'd13, 32'h0, 2'd1, 1'b0, 1'b1);
    capture(fr, -1);
    repeat (64) @(negedge clk);
    chk(status == 4'b0000, "R5 long window not expired", status, 0);
    @(negedge clk);
    chk(status == 4'b0011, "R5 timeout long window", status, 3);

    // R7 bad CRC, R8 bad stop bit, kind 3 no check
    launch(6'd17, 32'h0, 2'd1, 1'b0, 1'b0);
    capture(fr, -1);
    card_send(1, {88'd0, mk_short(6'd17, 32'h5, 1'b1, 1'b1)}, 48);
    chk(status == 4'b0101, "R7 short crc error", status, 5);
    launch(6'd17, 32'h0, 2'd1, 1'b0, 1'b0);
    capture(fr, -1);
    card_send(0, {88'd0, mk_short(6'd17, 32'h5, 1'b0, 1'b0)}, 48);
    chk(status == 4'b1001, "R8 stop bit error", status, 9);
    launch(6'd41, 32'h0, 2'd3, 1'b1, 1'b0);
    capture(fr, -1);
    card_send(2, {88'd0, mk_short(6'd63, 32'hFFFF_0000, 1'b1, 1'b1)}, 48);
    chk(status == 4'b0001, "R4/R7 kind 3 skips crc", status, 1);

    // R4/R6/R7/R9 long response, open drain, index 2
    lr = mk_long(120'h12_3456_789A_BCDE_F011_2233_4455_6677, 1'b0);
    launch(6'd2, 32'h0, 2'd2, 1'b1, 1'b0);
    capture(fr, -1);
    chk(fr == exp_frame(6'd2, 32'h0), "R1 index2 frame", fr, exp_frame(6'd2, 32'h0));
    card_send(3, lr, 136);
    chk(status == 4'b0001, "R7 long crc ok", status, 1);
    read_words(lr[127:0], "R9 long words");

    launch(6'd2, 32'h0, 2'd2, 1'b0, 1'b0);
    capture(fr, -1);
    card_send(0, mk_long(120'hABCDEF, 1'b1), 136);
    chk(status == 4'b0101, "R7 long crc error", status, 5);

    launch(6'd0, 32'h0, 2'd0, 1'b0, 1'b0);
    chk(status == 4'b0000, "R11 flags cleared", status, 0);
    capture(fr, -1);
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule